// File: doc/BRIEF.md
# Two-Channel Instruction-Fetch Break Unit

This block watches the instruction-fetch address stream of a processor and raises a debug interrupt when a fetch hits one of two programmed break addresses. Each channel holds a break address and an enable bit. A hit on a channel sets that channel's sticky match flag. Both channels drive one shared interrupt request, so the handler reads the status register to find out which channel fired.

The fetch stream is an observation-only input. It has a strobe and no ready, so the unit never stalls the fetch path. Two qualifiers go with each fetch. The first marks a fetch whose instruction will actually execute; a speculative fetch after a call, jump, trap or return is flagged as not executing. The second, a plain level input, says whether the CPU currently owns the bus. The unit starts in module-stop, driven by an external stop level that resets high. While stopped, it ignores register traffic and fetches. A flag is cleared only by a zero write that follows a read of that flag as one.

Top module: `pcbrk_unit`

## Requirements
- R1: While `mod_stop` is 1, no flag becomes set and register writes have no effect. Register reads return 0 and do not arm a clear. `irq` is 0 in the cycle after `mod_stop` was sampled high.
- R2: Register selector map: values 0 and 1 select the break address of channel 0 and channel 1 (full-width read/write). Value 2 is the enable register, where bit i enables channel i. Value 3 is status, where bit i is the flag of channel i. Writes commit at the clock edge, and reads are combinational.
- R3: A fetch sets flag i at the sampling edge when all of these hold: `fetch_vld`=1, `fetch_exec`=1, channel i is enabled, and `fetch_addr` equals break address i. A disabled channel never sets its flag.
- R4: Writing 0 to a flag bit that was not read as 1 since the last status write leaves the flag set.
- R5: A status read that sees flag i = 1, followed by a status write with bit i = 0, clears flag i. Writing 1 to the bit leaves the flag set. Every status write consumes the read arming.
- R6: A fetch with `fetch_exec`=0 never sets a flag, whatever its address.
- R7: `irq` is registered. It is 1 in the cycle after a cycle in which any flag is set, `cpu_bus`=1 and `mod_stop`=0, and it stays 1 while those conditions hold.
- R8: While `cpu_bus`=0, `irq` is held at 0 but the flags keep their value. `irq` appears one cycle after `cpu_bus` returns to 1 if a flag is still set.
- R9: A fetch that matches both channels sets both flags at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_stop | input | 1 | Module-stop level; 1 halts detection and register access |
| cpu_bus | input | 1 | 1 when the CPU owns the bus |
| fetch_vld | input | 1 | Fetch strobe (observe only, no back-pressure) |
| fetch_exec | input | 1 | 1 if the fetched instruction will execute |
| fetch_addr | input | ADDR_W | Fetch address |
| reg_sel | input | SEL_W | Register selector |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data |
| irq | output | 1 | Shared break interrupt request |

## Verification
The bench targets several corner cases, and each one has a visible failure mode in a faulty design:
- A zero write without a prior read. A design that clears on any zero write would drop the flag and lose the request.
- A matching fetch marked as not executing. A unit that ignores the qualifier would raise a break for a discarded fetch.
- A hit while another master holds the bus. A unit without deferral would assert `irq` early; one that drops the hit would never assert it.
- A hit during module-stop and a double-channel hit. A leaky stop gate would show a flag set, and a priority encoder would show only one flag.

// File: rtl/pcbrk_pkg.sv
package pcbrk_pkg;
  parameter int unsigned PB_NCH    = 2;
  parameter int unsigned PB_ADDR_W = 24;

  function automatic int unsigned pb_sel_w(input int unsigned nch);
    return $clog2(nch + 2);
  endfunction
endpackage

// File: rtl/pcbrk_chan.sv
module pcbrk_chan #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              en,
  input  logic              fetch_ok,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] brk_addr,
  output logic              hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       brk_addr <= '0;
    else if (addr_we) brk_addr <= wdata;
  end

  assign hit = fetch_ok && en && (fetch_addr == brk_addr);
endmodule

// File: rtl/pcbrk_flags.sv
module pcbrk_flags #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           st_rd,
  input  logic           st_wr,
  input  logic [NCH-1:0] st_wdata,
  output logic [NCH-1:0] flag,
  output logic [NCH-1:0] arm
);
  for (genvar i = 0; i < NCH; i++) begin : g_bit
    logic clr;
    assign clr = st_wr && !st_wdata[i] && arm[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[i] <= 1'b0;
        arm[i]  <= 1'b0;
      end else begin
        if (hit[i])   flag[i] <= 1'b1;
        else if (clr) flag[i] <= 1'b0;
        if (st_wr)      arm[i] <= 1'b0;
        else if (st_rd) arm[i] <= flag[i];
      end
    end
  end
endmodule

// File: rtl/pcbrk_unit.sv
module pcbrk_unit
  import pcbrk_pkg::*;
#(
  parameter  int unsigned NCH    = PB_NCH,
  parameter  int unsigned ADDR_W = PB_ADDR_W,
  localparam int unsigned SEL_W  = pb_sel_w(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_stop,
  input  logic              cpu_bus,
  input  logic              fetch_vld,
  input  logic              fetch_exec,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              irq
);
  localparam logic [SEL_W-1:0] SEL_EN = SEL_W'(NCH);
  localparam logic [SEL_W-1:0] SEL_ST = SEL_W'(NCH + 1);

  logic                          live;
  logic                          fetch_ok;
  logic [NCH-1:0]                en_q;
  logic [NCH-1:0]                hit;
  logic [NCH-1:0]                flag_q;
  logic [NCH-1:0]                arm_q;
  logic [NCH-1:0][ADDR_W-1:0]    brk_addr;

  assign live     = !mod_stop;
  assign fetch_ok = live && fetch_vld && fetch_exec;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic we;
    assign we = live && reg_wr && (reg_sel == SEL_W'(i));
    pcbrk_chan #(.ADDR_W(ADDR_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_we   (we),
      .wdata     (reg_wdata),
      .en        (en_q[i]),
      .fetch_ok  (fetch_ok),
      .fetch_addr(fetch_addr),
      .brk_addr  (brk_addr[i]),
      .hit       (hit[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  en_q <= '0;
    else if (live && reg_wr && reg_sel == SEL_EN) en_q <= reg_wdata[NCH-1:0];
  end

  pcbrk_flags #(.NCH(NCH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .st_rd   (live && reg_rd && reg_sel == SEL_ST),
    .st_wr   (live && reg_wr && reg_sel == SEL_ST),
    .st_wdata(reg_wdata[NCH-1:0]),
    .flag    (flag_q),
    .arm     (arm_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (live) begin
      if (reg_sel == SEL_EN)      reg_rdata = ADDR_W'(en_q);
      else if (reg_sel == SEL_ST) reg_rdata = ADDR_W'(flag_q);
      else begin
        for (int i = 0; i < NCH; i++)
          if (reg_sel == SEL_W'(i)) reg_rdata = brk_addr[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= live && cpu_bus && (|flag_q);
  end
endmodule

// File: rtl/pcbrk_chk.sv
module pcbrk_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mod_stop,
  input logic           cpu_bus,
  input logic           fetch_vld,
  input logic           fetch_exec,
  input logic           st_wr_any,
  input logic [NCH-1:0] st_wdata,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] arm,
  input logic [NCH-1:0] hit,
  input logic           irq
);
  a_r1_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mod_stop |=> !irq);

  a_r8_defer: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_bus |=> !irq);

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_stop && cpu_bus && flag != '0) |=> irq);

  for (genvar i = 0; i < NCH; i++) begin : g_c
    a_r1_no_rise_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> !$past(mod_stop));
    a_r3_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> $past(hit[i]));
    a_r6_rise_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> $past(fetch_vld && fetch_exec));
    a_r4_fall_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(st_wr_any && !st_wdata[i] && arm[i]));
  end
endmodule

bind pcbrk_unit pcbrk_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mod_stop  (mod_stop),
  .cpu_bus   (cpu_bus),
  .fetch_vld (fetch_vld),
  .fetch_exec(fetch_exec),
  .st_wr_any (u_flags.st_wr),
  .st_wdata  (reg_wdata[NCH-1:0]),
  .flag      (flag_q),
  .arm       (arm_q),
  .hit       (hit),
  .irq       (irq)
);

// File: tb/sim_pcbrk_unit.sv
`timescale 1ns/1ps
module sim_pcbrk_unit;
  localparam int AW = 24;
  localparam logic [1:0] S_A = 2'd0, S_B = 2'd1, S_EN = 2'd2, S_ST = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mod_stop = 1'b1;
  logic          cpu_bus = 1'b1;
  logic          fetch_vld = 1'b0;
  logic          fetch_exec = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [1:0]    reg_sel = '0;
  logic          reg_rd = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pcbrk_unit u0 (
    .clk(clk), .rst_n(rst_n), .mod_stop(mod_stop), .cpu_bus(cpu_bus),
    .fetch_vld(fetch_vld), .fetch_exec(fetch_exec), .fetch_addr(fetch_addr),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [AW-1:0] d);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_fetch(input logic [AW-1:0] a, input logic ex);
    @(negedge clk);
    fetch_addr = a; fetch_exec = ex; fetch_vld = 1'b1;
    @(negedge clk);
    fetch_vld = 1'b0; fetch_exec = 1'b0;
  endtask

  task automatic clear_all();
    logic [AW-1:0] d;
    bus_rd(S_ST, d);
    bus_wr(S_ST, '0);
  endtask

  task automatic t_reset_stop();
    logic [AW-1:0] d;
    check("R1", "irq after reset", irq, 0);
    bus_rd(S_ST, d);
    check("R1", "status read in stop", d, 0);
    bus_wr(S_A, 24'h00ABCD);
    bus_wr(S_EN, 24'h3);
    @(negedge clk); mod_stop = 1'b0;
    bus_rd(S_A, d);
    check("R1", "addr write ignored in stop", d, 0);
    bus_rd(S_EN, d);
    check("R1", "enable write ignored in stop", d, 0);
    bus_wr(S_A, 24'h001234);
    bus_wr(S_EN, 24'h1);
    bus_rd(S_A, d);
    check("R2", "break addr A readback", d, 24'h001234);
    @(negedge clk); mod_stop = 1'b1;
    do_fetch(24'h001234, 1'b1);
    @(negedge clk); mod_stop = 1'b0;
    bus_rd(S_ST, d);
    check("R1", "no flag from fetch in stop", d, 0);
  endtask

  task automatic t_match_a();
    logic [AW-1:0] d;
    do_fetch(24'h001230, 1'b1);
    @(negedge clk);
    check("R3", "no irq on miss", irq, 0);
    do_fetch(24'h001234, 1'b1);
    @(negedge clk);
    check("R7", "irq after hit A", irq, 1);
  endtask

  task automatic t_clear_no_read();
    logic [AW-1:0] d;
    bus_wr(S_ST, '0);
    @(negedge clk);
    check("R7", "irq persists", irq, 1);
    bus_rd(S_ST, d);
    check("R4", "flag kept after unarmed zero write", d, 24'h1);
  endtask

  task automatic t_read_clear();
    logic [AW-1:0] d;
    bus_wr(S_ST, 24'h1);
    bus_rd(S_ST, d);
    check("R5", "one write keeps flag", d, 24'h1);
    bus_wr(S_ST, '0);
    @(negedge clk);
    bus_rd(S_ST, d);
    check("R5", "flag cleared by armed zero", d, 0);
    check("R7", "irq drops after clear", irq, 0);
  endtask

  task automatic t_match_b_both();
    logic [AW-1:0] d;
    bus_wr(S_B, 24'h00BEEF);
    do_fetch(24'h00BEEF, 1'b1);
    bus_rd(S_ST, d);
    check("R3", "disabled B no flag", d, 0);
    bus_wr(S_EN, 24'h3);
    do_fetch(24'h00BEEF, 1'b1);
    bus_rd(S_ST, d);
    check("R3", "hit on B", d, 24'h2);
    check("R7", "irq for B", irq, 1);
    clear_all();
    bus_wr(S_B, 24'h001234);
    do_fetch(24'h001234, 1'b1);
    bus_rd(S_ST, d);
    check("R9", "both flags same fetch", d, 24'h3);
    clear_all();
  endtask

  task automatic t_discard();
    logic [AW-1:0] d;
    do_fetch(24'h001234, 1'b0);
    @(negedge clk);
    bus_rd(S_ST, d);
    check("R6", "discarded fetch no flag", d, 0);
    check("R6", "discarded fetch no irq", irq, 0);
  endtask

  task automatic t_foreign_bus();
    logic [AW-1:0] d;
    @(negedge clk); cpu_bus = 1'b0;
    do_fetch(24'h001234, 1'b1);
    @(negedge clk); @(negedge clk);
    check("R8", "irq deferred", irq, 0);
    bus_rd(S_ST, d);
    check("R8", "flags kept while deferred", d, 24'h3);
    cpu_bus = 1'b1;
    @(negedge clk);
    check("R8", "irq after bus return", irq, 1);
    @(negedge clk); mod_stop = 1'b1;
    @(negedge clk);
    check("R1", "irq masked in stop", irq, 0);
    mod_stop = 1'b0;
    clear_all();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_stop();
    t_match_a();
    t_clear_no_read();
    t_read_clear();
    t_match_b_both();
    t_discard();
    t_foreign_bus();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule